// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Engine

This block is the host side of a single-wire debug link. It clocks at the same rate as the target's debug clock and turns one byte into eight bit slots on the wire, most significant bit first. The host opens every slot, including the slots in which the target sends data. When the host sends a bit, it drives the wire low and then actively high, and the length of the low phase carries the value. When the host reads a bit, it pulls the wire low for a short time and then lets go, so that the target can hold the wire low or leave it high. The engine then reads a synchronized copy of the wire late in the slot.

Commands enter on a valid/ready port that carries a direction bit and a byte. `cmd_ready` is high only while the engine is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a byte is in progress, the upstream side must hold or repeat its command, and whatever sits on the command port has no effect. The result port has no back-pressure. `rsp_valid` is a one-cycle pulse, and the consumer must capture `rsp_data` in that cycle. The wire is split into a drive enable, a drive value and a raw input. An external pull-up holds the wire high whenever nobody drives it.

Top module: `swd_host_engine`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. After a command is accepted, `busy` is high for exactly 128 cycles (8 slots of 16 cycles).
- R2: Bits go onto the wire most significant bit first, and bits read from the wire are shifted in most significant bit first.
- R3: The first slot starts (wire driven low) in the cycle right after acceptance. Within a byte, consecutive slots start exactly 16 cycles apart.
- R4: A transmitted 1 (`cmd_dir`=0) is driven low for 4 cycles and then driven high for the rest of its slot.
- R5: A transmitted 0 is driven low for 13 cycles and then driven high for the rest of its slot.
- R6: In a receive slot (`cmd_dir`=1), the host drives low for exactly 2 cycles and leaves `pin_oe` low for the rest of the slot.
- R7: A received bit is the value of a two-flop synchronized copy of `pin_in`, taken at slot cycle 10. In effect this is the wire level at slot cycle 8.
- R8: `rsp_valid` pulses for one cycle, in the first cycle with `busy` low after a byte. `rsp_data` then carries the received byte for a receive command, or 0 for a transmit command.
- R9: `pin_oe` is low whenever `busy` is low.
- R10: Command inputs presented while `busy` is high are ignored. The byte on the wire and the result are those of the accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the target debug clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; the command is taken on this edge |
| cmd_dir | input | 1 | 0 = transmit byte, 1 = receive byte |
| cmd_data | input | 8 | Byte to transmit |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | 8 | Received byte (0 after a transmit) |
| busy | output | 1 | A byte is in progress |
| pin_in | input | 1 | Raw level of the debug wire |
| pin_oe | output | 1 | Host drives the wire |
| pin_out | output | 1 | Level driven when `pin_oe` is high |

## Verification
On every cycle, the assertions check that the wire is released while idle, that a receive slot stops driving after its two low cycles, and that a transmit slot ends driven high. They also check that the first slot opens right after acceptance, that the result is a single pulse, and that the busy window is exactly 128 cycles long. Only the bench scenarios can show that data is right. A target model decodes low-phase lengths into bytes and drives receive bits onto the wire. Those scenarios also show that slots are spaced 16 cycles apart, that the receive sample lands inside the window the target holds, and that commands presented during a byte leave it untouched.

// File: rtl/swd_pkg.sv
package swd_pkg;
  typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} swd_dir_e;
endpackage

// File: rtl/swd_in_sync.sv
module swd_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= raw_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/swd_slot_timer.sv
module swd_slot_timer #(
  parameter int BIT_CYC   = 16,
  parameter int DATA_W    = 8,
  parameter int SAMPLE_AT = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       run,
  output logic [$clog2(BIT_CYC)-1:0] cyc,
  output logic                       bit_end,
  output logic                       byte_end,
  output logic                       sample_now
);
  localparam int CYC_W = $clog2(BIT_CYC);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      idx <= '0;
    end else if (start) begin
      cyc <= '0;
      idx <= '0;
    end else if (run) begin
      if (cyc == LAST_CYC) begin
        cyc <= '0;
        idx <= idx + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  assign bit_end    = run && (cyc == LAST_CYC);
  assign byte_end   = bit_end && (idx == LAST_IDX);
  assign sample_now = run && (cyc == CYC_W'(SAMPLE_AT));
endmodule

// File: rtl/swd_slot_drive.sv
module swd_slot_drive
  import swd_pkg::*;
#(
  parameter int BIT_CYC  = 16,
  parameter int LOW_ONE  = 4,
  parameter int LOW_ZERO = 13,
  parameter int RX_LOW   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  swd_dir_e                   dir,
  input  logic                       tx_bit,
  input  logic [$clog2(BIT_CYC)-1:0] cyc,
  output logic                       pin_oe,
  output logic                       pin_out
);
  localparam int CYC_W = $clog2(BIT_CYC);
  localparam logic [CYC_W-1:0] ONE_END  = CYC_W'(LOW_ONE);
  localparam logic [CYC_W-1:0] ZERO_END = CYC_W'(LOW_ZERO);
  localparam logic [CYC_W-1:0] RX_END   = CYC_W'(RX_LOW);

  always_comb begin
    pin_oe  = 1'b0;
    pin_out = 1'b1;
    if (run) begin
      if (dir == DIR_TX) begin
        pin_oe  = 1'b1;
        pin_out = (cyc >= (tx_bit ? ONE_END : ZERO_END));
      end else begin
        pin_oe  = (cyc < RX_END);
        pin_out = 1'b0;
      end
    end
  end

  // R6
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir == DIR_RX && cyc >= RX_END) |-> !pin_oe);

  // R4
  tx_tail_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dir == DIR_TX && cyc == CYC_W'(BIT_CYC - 1)) |-> (pin_oe && pin_out));
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BIT_CYC     = 16,
  parameter int LOW_ONE     = 4,
  parameter int LOW_ZERO    = 13,
  parameter int RX_LOW      = 2,
  parameter int SAMPLE_AT   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_dir,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  input  logic              pin_in,
  output logic              pin_oe,
  output logic              pin_out
);
  localparam int CYC_W       = $clog2(BIT_CYC);
  localparam int BUSY_CYCLES = DATA_W * BIT_CYC;
  localparam int BC_W        = $clog2(BUSY_CYCLES + 1);

  logic             accept;
  swd_dir_e         dir_q;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CYC_W-1:0] tmr_cyc;
  logic             bit_end, byte_end, sample_now;
  logic             pin_sync;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign rsp_data  = rx_sh;

  swd_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync)
  );

  swd_slot_timer #(.BIT_CYC(BIT_CYC), .DATA_W(DATA_W), .SAMPLE_AT(SAMPLE_AT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy),
    .cyc(tmr_cyc), .bit_end(bit_end), .byte_end(byte_end), .sample_now(sample_now)
  );

  swd_slot_drive #(.BIT_CYC(BIT_CYC), .LOW_ONE(LOW_ONE), .LOW_ZERO(LOW_ZERO),
                   .RX_LOW(RX_LOW)) u_drive (
    .clk(clk), .rst_n(rst_n), .run(busy), .dir(dir_q), .tx_bit(tx_sh[DATA_W-1]),
    .cyc(tmr_cyc), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      dir_q     <= DIR_TX;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= busy && byte_end;
      if (accept) begin
        busy  <= 1'b1;
        dir_q <= swd_dir_e'(cmd_dir);
        tx_sh <= cmd_data;
        rx_sh <= '0;
      end else if (busy) begin
        if (sample_now && dir_q == DIR_RX) rx_sh <= {rx_sh[DATA_W-2:0], pin_sync};
        if (bit_end) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (byte_end) busy <= 1'b0;
      end
    end
  end

  // Checker state: length of the current busy window
  logic [BC_W-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;

  // R1
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == BC_W'(BUSY_CYCLES)));

  // R3
  first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pin_oe && !pin_out));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pin_oe);
endmodule

// File: tb/swd_host_engine_bench.sv
module swd_host_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_dir = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, rsp_valid, busy, pin_oe, pin_out;
  logic [7:0] rsp_data;
  logic       tgt_low = 1'b0;
  logic       pin_in;

  int checks = 0;
  int fails  = 0;

  typedef struct { logic dir; logic [7:0] data; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  // Wire: host drive wins, else target pull-down, else pull-up
  assign pin_in = pin_oe ? pin_out : (tgt_low ? 1'b0 : 1'b1);

  swd_host_engine u_swd_host_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dir(cmd_dir), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Target model + monitor, evaluated on the falling edge
  logic       tgt_en = 1'b0;
  logic [7:0] tgt_byte = 8'h00;
  int         tgt_idx = 0;
  logic       tgt_bit = 1'b1;
  int         tcnt = 0;
  logic       prev_dl = 1'b0;
  int         low_run = 0;
  int         since_fall = 0;
  int         nbits = 0;
  logic [7:0] tx_acc = 8'h00;
  int         busy_cnt = 0;
  logic       rsp_seen = 1'b0;

  always @(negedge clk) begin
    logic dl;
    exp_t e;
    if (rst_n) begin
      dl = pin_oe && !pin_out;
      since_fall++;
      tcnt++;
      if (rsp_seen) chk(!rsp_valid, "R8 pulse width", rsp_valid, 0);
      rsp_seen = rsp_valid;
      if (busy) busy_cnt++;
      if (dl && !prev_dl) begin
        if (nbits > 0) chk(since_fall == 16, "R3 slot spacing", since_fall, 16);
        since_fall = 0;
        low_run = 1;
        tcnt = 0;
        if (tgt_en) begin
          tgt_bit = tgt_byte[7 - tgt_idx];
          tgt_idx++;
        end
      end else if (dl) begin
        low_run++;
      end
      if (!dl && prev_dl && q.size() > 0) begin
        e = q[0];
        if (e.dir == 1'b0) begin
          chk(pin_oe && pin_out, "R4 driven high after low", pin_oe, 1);
          chk(low_run == 4 || low_run == 13, "R5 low length", low_run, 4);
          tx_acc = {tx_acc[6:0], (low_run == 4)};
        end else begin
          chk(low_run == 2 && !pin_oe, "R6 receive low length", low_run, 2);
        end
        nbits++;
      end
      tgt_low = tgt_en && !tgt_bit && tcnt >= 1 && tcnt <= 12;
      prev_dl = dl;
      if (rsp_valid) begin
        chk(q.size() > 0, "R8 unexpected result", q.size(), 1);
        if (q.size() > 0) begin
          e = q.pop_front();
          chk(nbits == 8, "R2 bit count", nbits, 8);
          chk(busy_cnt == 128, "R1 busy length", busy_cnt, 128);
          if (e.dir == 1'b0) begin
            chk(tx_acc == e.data, "R2 transmitted byte", tx_acc, e.data);
            chk(rsp_data == 8'h00, "R8 data after transmit", rsp_data, 0);
          end else begin
            chk(rsp_data == e.data, "R7 received byte", rsp_data, e.data);
          end
        end
        nbits = 0;
        busy_cnt = 0;
      end
    end
  end

  // Driver: pushes the expected item, then runs one command to completion
  task automatic run_cmd(input logic dir, input logic [7:0] data, input bit junk);
    exp_t e;
    e.dir = dir;
    e.data = data;
    q.push_back(e);
    @(negedge clk);
    tgt_en = dir;
    tgt_byte = data;
    tgt_idx = 0;
    cmd_valid = 1'b1;
    cmd_dir = dir;
    cmd_data = dir ? 8'h5A : data;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && pin_oe && !pin_out, "R3 first slot opens", pin_oe, 1);
    chk(!cmd_ready, "R1 ready low while busy", cmd_ready, 0);
    if (junk) begin
      cmd_valid = 1'b1;
      cmd_dir = ~dir;
      cmd_data = ~data;
      repeat (60) @(negedge clk);
      chk(!cmd_ready && busy, "R10 busy holds", cmd_ready, 0);
      cmd_valid = 1'b0;
    end
    do @(negedge clk); while (!rsp_valid);
    chk(!pin_oe && cmd_ready, "R9 released when idle", pin_oe, 0);
    @(negedge clk);
    tgt_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !busy, "R1 reset ready", cmd_ready, 1);
    chk(!pin_oe, "R9 reset released", pin_oe, 0);
    chk(!rsp_valid, "R8 reset no result", rsp_valid, 0);
    run_cmd(1'b0, 8'hA5, 1'b0);
    run_cmd(1'b0, 8'h00, 1'b0);
    run_cmd(1'b0, 8'hFF, 1'b0);
    run_cmd(1'b0, 8'h81, 1'b0);
    run_cmd(1'b1, 8'h3C, 1'b0);
    run_cmd(1'b1, 8'hC1, 1'b0);
    run_cmd(1'b1, 8'h00, 1'b0);
    run_cmd(1'b1, 8'hFF, 1'b0);
    run_cmd(1'b0, 8'h6E, 1'b1);  // R10 transmit with junk on command port
    run_cmd(1'b1, 8'h97, 1'b1);  // R10 receive with junk on command port
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R8 all results seen", q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule